// File: doc/BRIEF.md
# Multi-Mode Effective Address Unit

This block turns the addressing fields of a decoded instruction into an effective address and an operand value. A caller presents a 4-bit mode code, a 16-bit address field, a register selector and the current program counter, and pulses `start` while `ready` is high. The unit then reads the register file through a combinational read port, issues zero, one or two reads to a single-port synchronous memory, and reports the effective address, the operand and an illegal-mode flag together with a one-cycle `done` pulse. The indexed mode also writes the incremented index back through the register file write port, so arrays can be stepped.

The controller is a single state machine with seven states. `ST_IDLE` waits for a start. `ST_CALC` reads the selected register and forms the first address sum. `ST_PTR_REQ` and `ST_PTR_WAIT` fetch a pointer word for the memory-indirect modes. `ST_OPD_REQ` and `ST_OPD_WAIT` fetch the operand. `ST_DONE` presents the results. Transitions: `ST_IDLE` to `ST_CALC` on an accepted start. `ST_CALC` to `ST_DONE` for an illegal code, the immediate mode or the register mode. `ST_CALC` to `ST_PTR_REQ` for a mode that needs a pointer. `ST_CALC` to `ST_OPD_REQ` for all other modes. `ST_PTR_REQ` to `ST_PTR_WAIT`, `ST_PTR_WAIT` to `ST_OPD_REQ`, `ST_OPD_REQ` to `ST_OPD_WAIT`, `ST_OPD_WAIT` to `ST_DONE`, and `ST_DONE` to `ST_IDLE`, each unconditionally.

Top module: `ea_unit`

## Requirements
- R1: While reset is asserted and after it is released, `ready` is 1 and `done`, `mem_re` and `rf_we` are 0.
- R2: A start is taken only when `ready` is 1; `ready` stays 0 from the edge that takes it until the `done` cycle has passed; a `start` pulse or changed fields while busy do not alter the result in progress.
- R3: Mode code 0 (immediate): `operand` equals the address field, `ea` is 0, and no memory read is made.
- R4: Mode code 3 (register): `operand` equals the selected register, `ea` is the register selector zero-extended, and no memory read is made.
- R5: Mode codes 1 (direct), 4 (register indirect), 5 (displacement) and 6 (PC relative) form the address as field, register, field plus register and field plus PC; exactly one read is made at that address and `operand` is the word returned.
- R6: Mode code 7 (indexed): the address is field plus register, one read is made there, and the selected register is written back incremented by one; no other mode writes the register file.
- R7: Mode code 2 (memory indirect): the first read is at the address field, the word returned is the effective address, and a second read there gives the operand.
- R8: Mode code 8 (post-indexed) reads a pointer at the field and adds the register to it; mode code 9 (pre-indexed) reads the pointer at field plus register and uses it unchanged; both then read the operand there.
- R9: Mode codes 10 to 15 raise `illegal` with `done`, report `ea` and `operand` as 0, and make no memory read and no register write; the flag clears on the next accepted start.
- R10: Every address sum and the index increment wrap modulo 2^16.
- R11: Read data is taken the cycle after `mem_re`, `mem_addr` is held through that cycle, and `done` is high for one cycle starting 1 + 2n clock edges after the accepting edge, where n is the number of reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to resolve one operand |
| ready | output | 1 | Unit is idle and will take a start |
| mode | input | 4 | Addressing mode code |
| afield | input | 16 | Instruction address field |
| rsel | input | 3 | Register selector |
| pc | input | 16 | Program counter of the instruction |
| rf_raddr | output | 3 | Register file read index |
| rf_rdata | input | 16 | Register file read data, combinational |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 3 | Register file write index |
| rf_wdata | output | 16 | Register file write data |
| mem_re | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 16 | Memory read data, one cycle after the request |
| done | output | 1 | Result valid, one cycle |
| ea | output | 16 | Effective address |
| operand | output | 16 | Operand value |
| illegal | output | 1 | Mode code was not recognised |

## Verification
Each of the ten legal codes is run with field, register and PC values chosen so that every address source gives a different sum, which separates a wrong base or offset choice and shows whether a pointer was used as the address or as the base for the index. The memory returns a byte-swapped, scrambled copy of the address, so a read at the wrong place, a read count off by one or a pointer taken as the operand all yield a different value. Sums that cross 0xFFFF and an index register at 0xFFFF probe the wrap, a repeat of the indexed mode shows the stepping, and every unused code followed by a legal one shows that the flag stays quiet and clears. A start pulse with different fields during a two-read access tells apart a unit that latches its inputs from one that follows them.

// File: rtl/ea_pkg.sv
package ea_pkg;

    typedef enum logic [3:0] {
        AM_IMM  = 4'd0,
        AM_DIR  = 4'd1,
        AM_IND  = 4'd2,
        AM_REG  = 4'd3,
        AM_RIND = 4'd4,
        AM_DISP = 4'd5,
        AM_REL  = 4'd6,
        AM_IDX  = 4'd7,
        AM_POST = 4'd8,
        AM_PRE  = 4'd9
    } am_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CALC,
        ST_PTR_REQ,
        ST_PTR_WAIT,
        ST_OPD_REQ,
        ST_OPD_WAIT,
        ST_DONE
    } st_e;

    typedef enum logic [1:0] {
        BASE_ZERO,
        BASE_FIELD,
        BASE_MEM
    } base_e;

    typedef enum logic [1:0] {
        OFF_ZERO,
        OFF_REG,
        OFF_PC
    } off_e;

    typedef struct packed {
        logic  legal;
        logic  ptr_rd;
        logic  opd_rd;
        logic  idx_inc;
        logic  from_field;
        logic  from_reg;
        base_e calc_base;
        off_e  calc_off;
        off_e  ptr_off;
    } am_ctl_t;

endpackage

// File: rtl/ea_mode_dec.sv
module ea_mode_dec
    import ea_pkg::*;
(
    input  logic [3:0] mode_code,
    output am_ctl_t    ctl
);

    always_comb begin
        ctl = '0;
        unique case (mode_code)
            AM_IMM: begin
                ctl.legal      = 1'b1;
                ctl.from_field = 1'b1;
            end
            AM_REG: begin
                ctl.legal    = 1'b1;
                ctl.from_reg = 1'b1;
            end
            AM_DIR: begin
                ctl.legal     = 1'b1;
                ctl.opd_rd    = 1'b1;
                ctl.calc_base = BASE_FIELD;
                ctl.calc_off  = OFF_ZERO;
            end
            AM_RIND: begin
                ctl.legal     = 1'b1;
                ctl.opd_rd    = 1'b1;
                ctl.calc_base = BASE_ZERO;
                ctl.calc_off  = OFF_REG;
            end
            AM_DISP: begin
                ctl.legal     = 1'b1;
                ctl.opd_rd    = 1'b1;
                ctl.calc_base = BASE_FIELD;
                ctl.calc_off  = OFF_REG;
            end
            AM_REL: begin
                ctl.legal     = 1'b1;
                ctl.opd_rd    = 1'b1;
                ctl.calc_base = BASE_FIELD;
                ctl.calc_off  = OFF_PC;
            end
            AM_IDX: begin
                ctl.legal     = 1'b1;
                ctl.opd_rd    = 1'b1;
                ctl.idx_inc   = 1'b1;
                ctl.calc_base = BASE_FIELD;
                ctl.calc_off  = OFF_REG;
            end
            AM_IND: begin
                ctl.legal     = 1'b1;
                ctl.ptr_rd    = 1'b1;
                ctl.opd_rd    = 1'b1;
                ctl.calc_base = BASE_FIELD;
                ctl.calc_off  = OFF_ZERO;
                ctl.ptr_off   = OFF_ZERO;
            end
            AM_POST: begin
                ctl.legal     = 1'b1;
                ctl.ptr_rd    = 1'b1;
                ctl.opd_rd    = 1'b1;
                ctl.calc_base = BASE_FIELD;
                ctl.calc_off  = OFF_ZERO;
                ctl.ptr_off   = OFF_REG;
            end
            AM_PRE: begin
                ctl.legal     = 1'b1;
                ctl.ptr_rd    = 1'b1;
                ctl.opd_rd    = 1'b1;
                ctl.calc_base = BASE_FIELD;
                ctl.calc_off  = OFF_REG;
                ctl.ptr_off   = OFF_ZERO;
            end
            default: begin
                ctl = '0;
            end
        endcase
    end

endmodule

// File: rtl/ea_addr_calc.sv
module ea_addr_calc
    import ea_pkg::*;
#(
    parameter int AW = 16
) (
    input  base_e          base_sel,
    input  off_e           off_sel,
    input  logic [AW-1:0]  field_word,
    input  logic [AW-1:0]  mem_word,
    input  logic [AW-1:0]  reg_word,
    input  logic [AW-1:0]  pc_word,
    output logic [AW-1:0]  sum
);

    logic [AW-1:0] base_val;
    logic [AW-1:0] off_val;

    always_comb begin
        unique case (base_sel)
            BASE_FIELD: base_val = field_word;
            BASE_MEM:   base_val = mem_word;
            default:    base_val = '0;
        endcase
    end

    always_comb begin
        unique case (off_sel)
            OFF_REG: off_val = reg_word;
            OFF_PC:  off_val = pc_word;
            default: off_val = '0;
        endcase
    end

    // Plain AW-bit add: the carry out is dropped, giving modulo 2^AW.
    assign sum = base_val + off_val;

endmodule

// File: rtl/ea_ctrl.sv
module ea_ctrl
    import ea_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic legal,
    input  logic ptr_rd,
    input  logic opd_rd,
    input  logic idx_inc,
    output st_e  state,
    output logic accept,
    output logic ready,
    output logic done,
    output logic mem_re,
    output logic rf_we
);

    st_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_nx = ST_CALC;
                end
            end
            ST_CALC: begin
                if (!legal) begin
                    state_nx = ST_DONE;
                end else if (ptr_rd) begin
                    state_nx = ST_PTR_REQ;
                end else if (opd_rd) begin
                    state_nx = ST_OPD_REQ;
                end else begin
                    state_nx = ST_DONE;
                end
            end
            ST_PTR_REQ:  state_nx = ST_PTR_WAIT;
            ST_PTR_WAIT: state_nx = ST_OPD_REQ;
            ST_OPD_REQ:  state_nx = ST_OPD_WAIT;
            ST_OPD_WAIT: state_nx = ST_DONE;
            ST_DONE:     state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        ready  = 1'b0;
        accept = 1'b0;
        done   = 1'b0;
        mem_re = 1'b0;
        rf_we  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                ready  = 1'b1;
                accept = start;
            end
            ST_CALC: begin
                rf_we = legal && idx_inc;
            end
            ST_PTR_REQ: begin
                mem_re = 1'b1;
            end
            ST_OPD_REQ: begin
                mem_re = 1'b1;
            end
            ST_DONE: begin
                done = 1'b1;
            end
            default: begin
                ready = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ea_unit.sv
module ea_unit
    import ea_pkg::*;
#(
    parameter int AW = 16,
    parameter int RW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          ready,
    input  logic [3:0]    mode,
    input  logic [AW-1:0] afield,
    input  logic [RW-1:0] rsel,
    input  logic [AW-1:0] pc,
    output logic [RW-1:0] rf_raddr,
    input  logic [AW-1:0] rf_rdata,
    output logic          rf_we,
    output logic [RW-1:0] rf_waddr,
    output logic [AW-1:0] rf_wdata,
    output logic          mem_re,
    output logic [AW-1:0] mem_addr,
    input  logic [AW-1:0] mem_rdata,
    output logic          done,
    output logic [AW-1:0] ea,
    output logic [AW-1:0] operand,
    output logic          illegal
);

    localparam int PADW = AW - RW;
    localparam logic [AW-1:0] ONE = AW'(1);

    logic [3:0]    mode_q;
    logic [AW-1:0] field_q;
    logic [RW-1:0] rsel_q;
    logic [AW-1:0] pc_q;
    logic [AW-1:0] ea_q;
    logic [AW-1:0] opd_q;
    logic          ill_q;

    am_ctl_t       ctl;
    st_e           state;
    logic          accept;
    base_e         base_sel;
    off_e          off_sel;
    logic [AW-1:0] sum;

    ea_mode_dec u_dec (
        .mode_code (mode_q),
        .ctl       (ctl)
    );

    ea_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .legal   (ctl.legal),
        .ptr_rd  (ctl.ptr_rd),
        .opd_rd  (ctl.opd_rd),
        .idx_inc (ctl.idx_inc),
        .state   (state),
        .accept  (accept),
        .ready   (ready),
        .done    (done),
        .mem_re  (mem_re),
        .rf_we   (rf_we)
    );

    // The pointer word from memory is the base only while it is returning.
    always_comb begin
        if (state == ST_PTR_WAIT) begin
            base_sel = BASE_MEM;
            off_sel  = ctl.ptr_off;
        end else begin
            base_sel = ctl.calc_base;
            off_sel  = ctl.calc_off;
        end
    end

    ea_addr_calc #(.AW(AW)) u_calc (
        .base_sel   (base_sel),
        .off_sel    (off_sel),
        .field_word (field_q),
        .mem_word   (mem_rdata),
        .reg_word   (rf_rdata),
        .pc_word    (pc_q),
        .sum        (sum)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= '0;
            field_q <= '0;
            rsel_q  <= '0;
            pc_q    <= '0;
            ea_q    <= '0;
            opd_q   <= '0;
            ill_q   <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        mode_q  <= mode;
                        field_q <= afield;
                        rsel_q  <= rsel;
                        pc_q    <= pc;
                        ill_q   <= 1'b0;
                    end
                end
                ST_CALC: begin
                    if (!ctl.legal) begin
                        ill_q <= 1'b1;
                        ea_q  <= '0;
                        opd_q <= '0;
                    end else if (ctl.from_field) begin
                        ea_q  <= '0;
                        opd_q <= field_q;
                    end else if (ctl.from_reg) begin
                        ea_q  <= {{PADW{1'b0}}, rsel_q};
                        opd_q <= rf_rdata;
                    end else begin
                        ea_q <= sum;
                    end
                end
                ST_PTR_WAIT: begin
                    ea_q <= sum;
                end
                ST_OPD_WAIT: begin
                    opd_q <= mem_rdata;
                end
                default: begin
                    ea_q <= ea_q;
                end
            endcase
        end
    end

    assign rf_raddr = rsel_q;
    assign rf_waddr = rsel_q;
    assign rf_wdata = rf_rdata + ONE;
    assign mem_addr = ea_q;
    assign ea       = ea_q;
    assign operand  = opd_q;
    assign illegal  = ill_q;

endmodule

// File: rtl/ea_unit_chk.sv
module ea_unit_chk #(
    parameter int AW = 16,
    parameter int RW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          ready,
    input logic [3:0]    mode,
    input logic          done,
    input logic          illegal,
    input logic          mem_re,
    input logic [AW-1:0] mem_addr,
    input logic          rf_we
);

    logic [2:0] rd_cnt;
    logic [3:0] mode_l;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_cnt <= '0;
            mode_l <= '0;
        end else if (start && ready) begin
            rd_cnt <= '0;
            mode_l <= mode;
        end else if (mem_re && rd_cnt != 3'd7) begin
            rd_cnt <= rd_cnt + 3'd1;
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |-> (ready && !done && !mem_re && !rf_we));

    p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && ready) |=> !ready);

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (!mem_re && !rf_we && !done));

    p_imm_no_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode_l == 4'd0) |-> rd_cnt == 3'd0);

    p_reg_no_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode_l == 4'd3) |-> rd_cnt == 3'd0);

    p_one_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (mode_l == 4'd1 || mode_l == 4'd4 || mode_l == 4'd5 || mode_l == 4'd6))
        |-> rd_cnt == 3'd1);

    p_idx_one_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode_l == 4'd7) |-> rd_cnt == 3'd1);

    p_only_idx_writes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> mode_l == 4'd7);

    p_ind_two_reads_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode_l == 4'd2) |-> rd_cnt == 3'd2);

    p_pre_post_two_reads_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (mode_l == 4'd8 || mode_l == 4'd9)) |-> rd_cnt == 3'd2);

    p_illegal_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && illegal) |-> (rd_cnt == 3'd0 && mode_l >= 4'd10));

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_addr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> ($stable(mem_addr) && !mem_re));

endmodule

bind ea_unit ea_unit_chk #(.AW(AW), .RW(RW)) u_chk (.*);

// File: tb/ea_unit_test.sv
module ea_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        ready;
    logic [3:0]  mode = '0;
    logic [15:0] afield = '0;
    logic [2:0]  rsel = '0;
    logic [15:0] pc = '0;
    logic [2:0]  rf_raddr;
    logic [15:0] rf_rdata;
    logic        rf_we;
    logic [2:0]  rf_waddr;
    logic [15:0] rf_wdata;
    logic        mem_re;
    logic [15:0] mem_addr;
    logic [15:0] mem_rdata;
    logic        done;
    logic [15:0] ea;
    logic [15:0] operand;
    logic        illegal;

    int compared = 0;
    int mismatched = 0;

    always #4 clk = ~clk;

    ea_unit uut (.*);

    function automatic logic [15:0] mf(input logic [15:0] a);
        return {a[7:0], a[15:8]} ^ 16'h5A3C;
    endfunction

    function automatic logic [15:0] init_reg(input int i);
        if (i == 7) return 16'hFFFF;
        if (i == 6) return 16'h0020;
        return 16'(i * 16'h0100 + 16'h0003);
    endfunction

    logic [15:0] regs [8];
    assign rf_rdata = regs[rf_raddr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) regs[i] <= init_reg(i);
        end else if (rf_we) begin
            regs[rf_waddr] <= rf_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (mem_re) mem_rdata <= mf(mem_addr);
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run_op(input string tag, input logic [3:0] m, input logic [15:0] a,
                          input logic [2:0] r, input logic [15:0] p, input int n_exp,
                          input logic [15:0] ad0, input logic [15:0] ad1,
                          input logic [15:0] ea_exp, input logic [15:0] opd_exp,
                          input logic ill_exp, input int wr_exp, input bit poke);
        int cyc = 0;
        int nrd = 0;
        int nwr = 0;
        bit busy_bad = 0;
        bit hung = 0;
        logic [15:0] got0 = '0;
        logic [15:0] got1 = '0;
        @(negedge clk);
        check({tag, " R2 ready before start"}, 32'(ready), 32'd1);
        start = 1'b1; mode = m; afield = a; rsel = r; pc = p;
        @(posedge clk);
        forever begin
            @(negedge clk);
            if (cyc == 0) start = 1'b0;
            if (poke) begin
                if (cyc == 1 || cyc == 2) begin
                    start = 1'b1; mode = 4'd0; afield = 16'hFFFF; rsel = 3'd6; pc = 16'h7777;
                end else if (cyc == 3) begin
                    start = 1'b0;
                end
            end
            if (mem_re) begin
                if (nrd == 0) got0 = mem_addr;
                if (nrd == 1) got1 = mem_addr;
                nrd++;
            end
            if (rf_we) nwr++;
            if (done) break;
            if (ready) busy_bad = 1;
            cyc++;
            if (cyc > 40) begin
                hung = 1;
                break;
            end
        end
        start = 1'b0;
        check({tag, " R11 no hang"}, 32'(hung), 32'd0);
        check({tag, " R2 busy while working"}, 32'(busy_bad), 32'd0);
        check({tag, " R11 latency"}, 32'(cyc), 32'(1 + 2 * n_exp));
        check({tag, " read count"}, 32'(nrd), 32'(n_exp));
        if (n_exp > 0) check({tag, " first read address"}, 32'(got0), 32'(ad0));
        if (n_exp > 1) check({tag, " second read address"}, 32'(got1), 32'(ad1));
        check({tag, " ea"}, 32'(ea), 32'(ea_exp));
        check({tag, " operand"}, 32'(operand), 32'(opd_exp));
        check({tag, " illegal flag"}, 32'(illegal), 32'(ill_exp));
        check({tag, " R6 register writes"}, 32'(nwr), 32'(wr_exp));
        @(negedge clk);
        check({tag, " R11 done one cycle"}, 32'(done), 32'd0);
        check({tag, " R2 ready after done"}, 32'(ready), 32'd1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 ready in reset", 32'(ready), 32'd1);
        check("R1 done in reset", 32'(done), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready after reset", 32'(ready), 32'd1);
        check("R1 quiet after reset", 32'({done, mem_re, rf_we}), 32'd0);
    endtask

    task automatic t_imm_reg();
        run_op("R3 immediate", 4'd0, 16'h1234, 3'd2, 16'h0, 0, 16'h0, 16'h0,
               16'h0000, 16'h1234, 1'b0, 0, 1'b0);
        run_op("R4 register", 4'd3, 16'h9999, 3'd2, 16'h0, 0, 16'h0, 16'h0,
               16'h0002, 16'h0203, 1'b0, 0, 1'b0);
    endtask

    task automatic t_single_read();
        run_op("R5 direct", 4'd1, 16'h0040, 3'd1, 16'h0, 1, 16'h0040, 16'h0,
               16'h0040, mf(16'h0040), 1'b0, 0, 1'b0);
        run_op("R5 register indirect", 4'd4, 16'h0555, 3'd1, 16'h0, 1, 16'h0103, 16'h0,
               16'h0103, mf(16'h0103), 1'b0, 0, 1'b0);
        run_op("R5 displacement", 4'd5, 16'h0200, 3'd3, 16'h0, 1, 16'h0503, 16'h0,
               16'h0503, mf(16'h0503), 1'b0, 0, 1'b0);
        run_op("R5 relative", 4'd6, 16'h0010, 3'd3, 16'h3000, 1, 16'h3010, 16'h0,
               16'h3010, mf(16'h3010), 1'b0, 0, 1'b0);
    endtask

    task automatic t_indexed();
        run_op("R6 indexed first", 4'd7, 16'h1000, 3'd4, 16'h0, 1, 16'h1403, 16'h0,
               16'h1403, mf(16'h1403), 1'b0, 1, 1'b0);
        run_op("R6 index readback", 4'd3, 16'h0, 3'd4, 16'h0, 0, 16'h0, 16'h0,
               16'h0004, 16'h0404, 1'b0, 0, 1'b0);
        run_op("R6 indexed step", 4'd7, 16'h1000, 3'd4, 16'h0, 1, 16'h1404, 16'h0,
               16'h1404, mf(16'h1404), 1'b0, 1, 1'b0);
    endtask

    task automatic t_pointer();
        logic [15:0] e;
        e = mf(16'h0077);
        run_op("R7 memory indirect", 4'd2, 16'h0077, 3'd0, 16'h0, 2, 16'h0077, e,
               e, mf(e), 1'b0, 0, 1'b0);
        e = mf(16'h0050) + 16'h0503;
        run_op("R8 post-indexed", 4'd8, 16'h0050, 3'd5, 16'h0, 2, 16'h0050, e,
               e, mf(e), 1'b0, 0, 1'b0);
        e = mf(16'h0303);
        run_op("R8 pre-indexed", 4'd9, 16'h0100, 3'd2, 16'h0, 2, 16'h0303, e,
               e, mf(e), 1'b0, 0, 1'b0);
    endtask

    task automatic t_wrap();
        run_op("R10 displacement wrap", 4'd5, 16'hFFF0, 3'd6, 16'h0, 1, 16'h0010, 16'h0,
               16'h0010, mf(16'h0010), 1'b0, 0, 1'b0);
        run_op("R10 relative wrap", 4'd6, 16'h8000, 3'd0, 16'h8001, 1, 16'h0001, 16'h0,
               16'h0001, mf(16'h0001), 1'b0, 0, 1'b0);
        run_op("R10 indexed wrap", 4'd7, 16'h0002, 3'd7, 16'h0, 1, 16'h0001, 16'h0,
               16'h0001, mf(16'h0001), 1'b0, 1, 1'b0);
        run_op("R10 increment wrap readback", 4'd3, 16'h0, 3'd7, 16'h0, 0, 16'h0, 16'h0,
               16'h0007, 16'h0000, 1'b0, 0, 1'b0);
    endtask

    task automatic t_illegal();
        for (int c = 10; c < 16; c++) begin
            run_op("R9 unused code", 4'(c), 16'h0040, 3'd1, 16'h1000, 0, 16'h0, 16'h0,
                   16'h0000, 16'h0000, 1'b1, 0, 1'b0);
        end
        run_op("R9 flag clears", 4'd0, 16'h00AA, 3'd0, 16'h0, 0, 16'h0, 16'h0,
               16'h0000, 16'h00AA, 1'b0, 0, 1'b0);
    endtask

    task automatic t_busy_start();
        logic [15:0] e;
        e = mf(16'h0123);
        run_op("R2 start while busy", 4'd2, 16'h0123, 3'd0, 16'h0, 2, 16'h0123, e,
               e, mf(e), 1'b0, 0, 1'b1);
        repeat (2) begin
            @(negedge clk);
            check("R2 no extra operation", 32'({done, mem_re, ready}), 32'b001);
        end
    endtask

    initial begin
        t_reset();
        t_imm_reg();
        t_single_read();
        t_indexed();
        t_pointer();
        t_wrap();
        t_illegal();
        t_busy_start();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual expired expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule